// File: doc/BRIEF.md
# MAC Pause and Backpressure Controller

This block decides when an Ethernet MAC transmitter may begin a new frame. A received flow-control frame loads a 16-bit timer. The timer counts pause quanta, and each quantum is a fixed number of byte-times. While the timer is nonzero, the block raises a transmit-inhibit level. The byte-time tick comes from a prescaler on the MAC clock, and its rate follows a 10/100 speed select.

Test controls can shorten the quantum to a single byte-time or force the inhibit on. Another control forces backpressure: when no system frame is on the wire, the block fills the line with the repeating preamble nibble so that the far end sees carrier. A system frame started during backpressure is still sent, and it takes the line from the preamble.

The inhibit only gates the start of a frame. A frame that is already between its start and end strobes always completes. The inhibit takes effect in the cycle after the end strobe.

Top module: `mac_pause_bp_ctrl`

## Requirements
- R1: After synchronous reset, and after any reset applied during a pause, tx_inhibit, bp_active and line_en are 0 and line_nib is 4'h0. All registered control bits reset to 0.
- R2: Each control input is registered and acts from the cycle after it is driven. A byte-time lasts FAST_DIV clocks (default 2) when cfg_speed_100 is 1 and SLOW_DIV clocks (default 20) when it is 0. A change of speed restarts the byte-time count.
- R3: A pause strobe with nonzero time N holds tx_inhibit high from the cycle after the strobe for exactly N x QUANTUM_BYTES (default 64) byte-times. The quantum and byte-time counts restart at the strobe.
- R4: With cfg_short_quanta set, one quantum is one byte-time, so a pause of N lasts N byte-times.
- R5: A pause strobe with time zero ends any pause in progress, and tx_inhibit is 0 from the next cycle.
- R6: A pause strobe that arrives during a pause reloads the timer with the new value and restarts the timing from that strobe.
- R7: While cfg_force_pause is set, tx_inhibit is 1 from the next cycle onward, independent of the timer, unless a frame is in progress.
- R8: tx_inhibit is 0 while a frame is in progress, which is the cycle after tx_sof through the cycle of tx_eof. A pending inhibit appears in the cycle after tx_eof.
- R9: With cfg_force_bp set, bp_active is 1 from the next cycle. Outside system frames, line_en is 1 and line_nib carries the preamble nibble 4'b0101.
- R10: During a system frame, from the tx_sof cycle through the tx_eof cycle, line_en is 1 and line_nib equals tx_nib even under backpressure. The preamble resumes in the cycle after tx_eof.
- R11: With no backpressure and no frame, line_en is 0 and line_nib is 4'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | MAC clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_speed_100 | input | 1 | 1 selects 100 Mbps byte-time, 0 selects 10 Mbps |
| cfg_short_quanta | input | 1 | Test: quantum of one byte-time |
| cfg_force_pause | input | 1 | Test: inhibit as if paused |
| cfg_force_bp | input | 1 | Test: force backpressure preamble |
| pause_rx_vld | input | 1 | One-cycle strobe for a received pause frame |
| pause_rx_time | input | 16 | Pause time in quanta carried by the strobe |
| tx_sof | input | 1 | One-cycle strobe for the first nibble of a system frame |
| tx_eof | input | 1 | One-cycle strobe for the last nibble of a system frame |
| tx_nib | input | 4 | System frame nibble |
| tx_inhibit | output | 1 | New frames must not start |
| bp_active | output | 1 | Backpressure is being applied |
| line_en | output | 1 | Line nibble is valid |
| line_nib | output | 4 | Nibble driven to the line |

## Verification
The assertions assume well-formed frame strobes. tx_sof arrives only when no frame is in progress and tx_inhibit was low. tx_eof arrives only inside a frame, and never in the same cycle as tx_sof. Pause strobes last a single cycle. The bench keeps to these rules: it opens each frame from an idle line, closes it a few cycles later with a separate strobe, and raises every strobe at a falling edge for exactly one clock.

// File: rtl/mac_pause_pkg.sv
package mac_pause_pkg;

    typedef struct packed {
        logic speed_100;
        logic short_quanta;
        logic force_pause;
        logic force_bp;
    } mpb_cfg_t;

    localparam logic [3:0] PREAMBLE_NIB = 4'b0101;
    localparam int unsigned PAUSE_W     = 16;

    typedef enum logic [1:0] {
        SRC_IDLE     = 2'd0,
        SRC_FRAME    = 2'd1,
        SRC_PREAMBLE = 2'd2
    } line_src_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mpb_byte_tick.sv
module mpb_byte_tick #(
    parameter int unsigned FAST_DIV = 2,
    parameter int unsigned SLOW_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic speed_fast,
    input  logic restart,
    output logic tick
);
    import mac_pause_pkg::*;

    localparam int unsigned MAXD = max_u(FAST_DIV, SLOW_DIV);
    localparam int unsigned CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          spd_prev;
    logic          spd_changed;
    logic          clr;

    assign lim         = speed_fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    assign spd_changed = (spd_prev != speed_fast);
    assign clr         = restart | spd_changed;
    assign tick        = (cnt >= lim) & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            spd_prev <= 1'b0;
        end else begin
            spd_prev <= speed_fast;
            if (clr || tick) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R2: with a divisor above one, two byte ticks never fall in adjacent cycles
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0 && !spd_changed) |=> !tick);

endmodule

// File: rtl/mpb_pause_timer.sv
module mpb_pause_timer #(
    parameter int unsigned QUANTUM_BYTES = 64,
    parameter int unsigned TW            = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_tick,
    input  logic          short_quanta,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          active
);
    localparam int unsigned QW = $clog2(QUANTUM_BYTES + 1);

    logic [QW-1:0] qcnt;
    logic [QW-1:0] qlim;
    logic          q_tick;
    logic [TW-1:0] timer;

    assign qlim   = short_quanta ? '0 : QW'(QUANTUM_BYTES - 1);
    assign q_tick = byte_tick & (qcnt >= qlim);
    assign active = (timer != '0);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            qcnt <= '0;
        end else if (byte_tick) begin
            if (q_tick) qcnt <= '0;
            else        qcnt <= qcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer <= '0;
        end else if (load) begin
            timer <= load_val;
        end else if (q_tick && active) begin
            timer <= timer - 1'b1;
        end
    end

    // R3 / R6: a strobe always replaces the count with the received time
    assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (timer == $past(load_val)));

    // R5: an idle timer stays idle until the next strobe
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !active) |=> !active);

    // R3: the count only moves on a quantum boundary
    assert_hold_between_quanta_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && active && !q_tick) |=> (timer == $past(timer)));

endmodule

// File: rtl/mpb_line_mux.sv
module mpb_line_mux (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_sof,
    input  logic       tx_eof,
    input  logic [3:0] tx_nib,
    input  logic       bp_on,
    output logic       in_frame,
    output logic       line_en,
    output logic [3:0] line_nib
);
    import mac_pause_pkg::*;

    line_src_e src;

    always_ff @(posedge clk) begin
        if (rst)         in_frame <= 1'b0;
        else if (tx_sof) in_frame <= 1'b1;
        else if (tx_eof) in_frame <= 1'b0;
    end

    always_comb begin
        if (tx_sof || in_frame) src = SRC_FRAME;
        else if (bp_on)         src = SRC_PREAMBLE;
        else                    src = SRC_IDLE;
    end

    always_comb begin
        unique case (src)
            SRC_FRAME: begin
                line_en  = 1'b1;
                line_nib = tx_nib;
            end
            SRC_PREAMBLE: begin
                line_en  = 1'b1;
                line_nib = PREAMBLE_NIB;
            end
            default: begin
                line_en  = 1'b0;
                line_nib = 4'h0;
            end
        endcase
    end

    // R10: the cycle after a start strobe still carries the system nibble
    assert_frame_priority_R10: assert property (@(posedge clk) disable iff (rst)
        tx_sof |=> (line_en && line_nib == tx_nib));

    // R9: after a frame under backpressure the preamble takes the line again
    assert_preamble_resumes_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_eof && bp_on) |=> (!bp_on || tx_sof || (line_en && line_nib == PREAMBLE_NIB)));

    // R11: after a frame without backpressure the line goes quiet
    assert_idle_line_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_eof && !bp_on) |=> (bp_on || tx_sof || (!line_en && line_nib == 4'h0)));

endmodule

// File: rtl/mac_pause_bp_ctrl.sv
module mac_pause_bp_ctrl
    import mac_pause_pkg::*;
#(
    parameter int unsigned FAST_DIV      = 2,
    parameter int unsigned SLOW_DIV      = 20,
    parameter int unsigned QUANTUM_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_speed_100,
    input  logic        cfg_short_quanta,
    input  logic        cfg_force_pause,
    input  logic        cfg_force_bp,
    input  logic        pause_rx_vld,
    input  logic [15:0] pause_rx_time,
    input  logic        tx_sof,
    input  logic        tx_eof,
    input  logic [3:0]  tx_nib,
    output logic        tx_inhibit,
    output logic        bp_active,
    output logic        line_en,
    output logic [3:0]  line_nib
);

    mpb_cfg_t cfg_q;
    logic     byte_tick;
    logic     pause_on;
    logic     in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q.speed_100    <= cfg_speed_100;
            cfg_q.short_quanta <= cfg_short_quanta;
            cfg_q.force_pause  <= cfg_force_pause;
            cfg_q.force_bp     <= cfg_force_bp;
        end
    end

    mpb_byte_tick #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_tick (
        .clk        (clk),
        .rst        (rst),
        .speed_fast (cfg_q.speed_100),
        .restart    (pause_rx_vld),
        .tick       (byte_tick)
    );

    mpb_pause_timer #(
        .QUANTUM_BYTES (QUANTUM_BYTES),
        .TW            (PAUSE_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .byte_tick    (byte_tick),
        .short_quanta (cfg_q.short_quanta),
        .load         (pause_rx_vld),
        .load_val     (pause_rx_time),
        .active       (pause_on)
    );

    mpb_line_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .tx_sof   (tx_sof),
        .tx_eof   (tx_eof),
        .tx_nib   (tx_nib),
        .bp_on    (cfg_q.force_bp),
        .in_frame (in_frame),
        .line_en  (line_en),
        .line_nib (line_nib)
    );

    assign tx_inhibit = (pause_on | cfg_q.force_pause) & ~in_frame;
    assign bp_active  = cfg_q.force_bp;

    // R7: a forced pause shows up one cycle later unless a frame holds the line
    assert_force_pause_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_force_pause |=> (tx_inhibit || in_frame));

    // R5: a zero-time strobe releases the inhibit unless it is forced
    assert_zero_release_R5: assert property (@(posedge clk) disable iff (rst)
        (pause_rx_vld && pause_rx_time == 16'h0 && !cfg_force_pause) |=> !tx_inhibit);

endmodule

// File: tb/sim_mac_pause_bp_ctrl.sv
module sim_mac_pause_bp_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_speed_100, cfg_short_quanta, cfg_force_pause, cfg_force_bp;
    logic        pause_rx_vld;
    logic [15:0] pause_rx_time;
    logic        tx_sof, tx_eof;
    logic [3:0]  tx_nib;
    logic        tx_inhibit, bp_active, line_en;
    logic [3:0]  line_nib;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mac_pause_bp_ctrl u0 (
        .clk              (clk),
        .rst              (rst),
        .cfg_speed_100    (cfg_speed_100),
        .cfg_short_quanta (cfg_short_quanta),
        .cfg_force_pause  (cfg_force_pause),
        .cfg_force_bp     (cfg_force_bp),
        .pause_rx_vld     (pause_rx_vld),
        .pause_rx_time    (pause_rx_time),
        .tx_sof           (tx_sof),
        .tx_eof           (tx_eof),
        .tx_nib           (tx_nib),
        .tx_inhibit       (tx_inhibit),
        .bp_active        (bp_active),
        .line_en          (line_en),
        .line_nib         (line_nib)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_speed_100 = 1'b1; cfg_short_quanta = 1'b0;
        cfg_force_pause = 1'b0; cfg_force_bp = 1'b0;
        pause_rx_vld = 1'b0; pause_rx_time = 16'h0;
        tx_sof = 1'b0; tx_eof = 1'b0; tx_nib = 4'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input logic fast, input logic shortq);
        @(negedge clk);
        cfg_speed_100 = fast; cfg_short_quanta = shortq;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_pause(input int n);
        pause_rx_vld = 1'b1; pause_rx_time = 16'(n);
        @(negedge clk);
        pause_rx_vld = 1'b0; pause_rx_time = 16'h0;
    endtask

    // counts falling edges with tx_inhibit high, starting from the current one
    task automatic measure(output int len);
        len = 0;
        while (tx_inhibit && len < 20000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int len;
        do_reset();
        check("R1 inhibit", tx_inhibit, 0);
        check("R1 bp_active", bp_active, 0);
        check("R1 line_en", line_en, 0);
        check("R1 line_nib", line_nib, 0);
        set_cfg(1'b1, 1'b1);
        @(negedge clk);
        pulse_pause(100);
        check("R1 pause started", tx_inhibit, 1);
        do_reset();
        len = 0;
        check("R1 inhibit after reset in pause", tx_inhibit, 0);
    endtask

    task automatic t_pause(input string req, input logic fast, input logic shortq,
                           input int n, input int exp_len);
        int len;
        set_cfg(fast, shortq);
        @(negedge clk);
        pulse_pause(n);
        measure(len);
        check(req, len, exp_len);
    endtask

    task automatic t_zero();
        set_cfg(1'b1, 1'b1);
        @(negedge clk);
        pulse_pause(50);
        repeat (3) @(negedge clk);
        check("R5 paused before zero", tx_inhibit, 1);
        pulse_pause(0);
        check("R5 zero clears", tx_inhibit, 0);
        repeat (5) @(negedge clk);
        check("R5 stays clear", tx_inhibit, 0);
    endtask

    task automatic t_reload();
        int len;
        set_cfg(1'b1, 1'b1);
        @(negedge clk);
        pulse_pause(3);
        repeat (4) @(negedge clk);
        pulse_pause(10);
        measure(len);
        check("R6 reload length", len, 20);
    endtask

    task automatic t_force_pause();
        @(negedge clk);
        cfg_force_pause = 1'b1;
        @(negedge clk);
        check("R7 forced on", tx_inhibit, 1);
        repeat (200) @(negedge clk);
        check("R7 forced held", tx_inhibit, 1);
        cfg_force_pause = 1'b0;
        @(negedge clk);
        check("R7 forced off", tx_inhibit, 0);
    endtask

    task automatic t_frame_guard();
        set_cfg(1'b1, 1'b1);
        @(negedge clk);
        tx_sof = 1'b1; tx_nib = 4'h3;
        @(negedge clk);
        tx_sof = 1'b0;
        pulse_pause(40);
        check("R8 no inhibit in frame", tx_inhibit, 0);
        cfg_force_pause = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 force masked in frame", tx_inhibit, 0);
        tx_eof = 1'b1;
        #1;
        check("R8 eof cycle", tx_inhibit, 0);
        @(negedge clk);
        tx_eof = 1'b0;
        check("R8 inhibit after eof", tx_inhibit, 1);
        cfg_force_pause = 1'b0;
        pulse_pause(0);
        check("R8 released", tx_inhibit, 0);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        check("R11 idle line_en", line_en, 0);
        check("R11 idle nib", line_nib, 0);
        cfg_force_bp = 1'b1;
        #1;
        check("R9 bp registered", bp_active, 0);
        @(negedge clk);
        check("R9 bp_active", bp_active, 1);
        check("R9 line_en", line_en, 1);
        check("R9 preamble", line_nib, 5);
        tx_sof = 1'b1; tx_nib = 4'hA;
        #1;
        check("R10 sof nibble", line_nib, 10);
        @(negedge clk);
        tx_sof = 1'b0; tx_nib = 4'hC;
        #1;
        check("R10 mid nibble", line_nib, 12);
        check("R10 line_en mid", line_en, 1);
        @(negedge clk);
        tx_eof = 1'b1; tx_nib = 4'h0;
        #1;
        check("R10 eof nibble", line_nib, 0);
        @(negedge clk);
        tx_eof = 1'b0; tx_nib = 4'hF;
        #1;
        check("R10 preamble resumes", line_nib, 5);
        cfg_force_bp = 1'b0;
        @(negedge clk);
        check("R11 bp off", bp_active, 0);
        check("R11 line quiet", line_en, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        t_reset();
        t_pause("R2 R4 fast short", 1'b1, 1'b1, 4, 8);
        t_pause("R2 R4 slow short", 1'b0, 1'b1, 4, 80);
        t_pause("R3 fast normal", 1'b1, 1'b0, 2, 256);
        t_pause("R3 R2 slow normal", 1'b0, 1'b0, 1, 1280);
        t_zero();
        t_reload();
        t_force_pause();
        t_frame_guard();
        t_backpressure();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule